// File: doc/BRIEF.md
# Parallel-load serial-out shift register

This block turns a parallel word into a serial bit stream. On each rising edge of a free-running clock it either captures a whole parallel word into its stages or shifts every stage up by one position, with a serial input entering the lowest stage. Only the top stage is visible, as the serial output. An active-low clock enable freezes the register, and an active-low asynchronous clear empties it at once, whatever the other inputs are doing.

To build a wider converter, instances are chained. The serial output of one instance drives the serial input of the next. All instances share the clock, enable, load select and clear. The last instance in the chain emits its own word first, most significant bit leading, and then the words of the instances upstream of it.

Top module: `piso_shift_reg`

## Requirements
- R1: While rst_ni is low, every stage is 0 and ser_o is 0. The clear takes effect as soon as rst_ni falls, without waiting for a clock edge, and it overrides the enable and the load select.
- R2: At a rising edge with en_ni high, no stage changes. This holds even when load_ni is low, so a disabled clock blocks parallel loads as well as shifts.
- R3: At a rising edge with en_ni low and load_ni low, stage k takes par_i[k] for every k, so ser_o shows par_i[WIDTH-1] after that edge.
- R4: At a rising edge with en_ni low and load_ni high, stage 0 takes ser_i and stage k takes the old value of stage k-1, for k from 1 to WIDTH-1.
- R5: After a parallel load, WIDTH-1 enabled shifts present the loaded bits on ser_o in the order par_i[WIDTH-1], par_i[WIDTH-2], ..., par_i[0]. The first bit appears right after the load, and each later bit appears after one more shift.
- R6: During uninterrupted enabled shifting, ser_o after shift n equals the ser_i value sampled at shift n-(WIDTH-1).
- R7: When two instances are chained and loaded in the same cycle, the final ser_o shows the downstream word, most significant bit first, followed by the upstream word, most significant bit first, over 2*WIDTH consecutive observations separated by enabled shifts.
- R8: After reset is released, ser_o stays 0 until a load or a shift brings in a 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock, rising edge active |
| rst_ni | input | 1 | Asynchronous clear, active low |
| en_ni | input | 1 | Synchronous clock enable, active low |
| load_ni | input | 1 | Selects a parallel load when low and a shift when high |
| ser_i | input | 1 | Serial input into stage 0 |
| par_i | input | WIDTH | Parallel data; bit k goes to stage k |
| ser_o | output | 1 | Top stage (stage WIDTH-1) |

## Verification
Four properties are checked at every clock edge: the stage vector holds while the enable is inactive, a load presents the top parallel bit, a shift moves every stage by one position with the serial input entering stage 0, and the register reads zero at any edge where the clear is held. Some behaviour only shows up in the bench's scenarios, because it spans many cycles or falls between clock edges. This covers the order in which a loaded word leaves the register, the shift-length delay from serial input to output, the word order of a two-instance chain, and the output dropping to zero as soon as the clear falls mid-cycle.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_SHIFT = 2'd2
  } mode_e;
endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
(
  input  logic  en_ni,
  input  logic  load_ni,
  output mode_e mode_o
);
  // enable outranks the load/shift choice
  always_comb begin
    if (en_ni)         mode_o = MODE_HOLD;
    else if (!load_ni) mode_o = MODE_LOAD;
    else               mode_o = MODE_SHIFT;
  end
endmodule

// File: rtl/piso_stage.sv
module piso_stage
  import piso_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  par_i,
  input  logic  prev_i,
  output logic  q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= 1'b0;
    end else begin
      case (mode_i)
        MODE_LOAD:  q_o <= par_i;
        MODE_SHIFT: q_o <= prev_i;
        default:    q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
  import piso_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_ni,
  input  logic             load_ni,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             ser_o
);
  localparam int unsigned LastIdx = WIDTH - 1;

  mode_e            mode;
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] prev_d;

  piso_ctrl u_ctrl (
    .en_ni  (en_ni),
    .load_ni(load_ni),
    .mode_o (mode)
  );

  // stage k is fed from stage k-1; stage 0 from the serial input
  assign prev_d = {stage_q[LastIdx-1:0], ser_i};

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    piso_stage u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .mode_i(mode),
      .par_i (par_i[k]),
      .prev_i(prev_d[k]),
      .q_o   (stage_q[k])
    );
  end

  assign ser_o = stage_q[LastIdx];
endmodule

// File: rtl/piso_shift_reg_chk.sv
module piso_shift_reg_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_ni,
  input logic             load_ni,
  input logic             ser_i,
  input logic [WIDTH-1:0] par_i,
  input logic [WIDTH-1:0] stage_q,
  input logic             ser_o
);
  // clear observed at any edge where it is held
  a_r1_clear_empties: assert property (@(posedge clk_i)
    !rst_ni |-> (stage_q == '0 && ser_o == 1'b0));

  a_r2_hold_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |=> ($stable(stage_q) && $stable(ser_o)));

  a_r3_load_shows_top_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ni && !load_ni) |=> (ser_o == $past(par_i[WIDTH-1])));

  a_r4_shift_moves_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ni && load_ni) |=>
      (stage_q[WIDTH-1:1] == $past(stage_q[WIDTH-2:0]) && stage_q[0] == $past(ser_i)));
endmodule

bind piso_shift_reg piso_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_ni  (en_ni),
  .load_ni(load_ni),
  .ser_i  (ser_i),
  .par_i  (par_i),
  .stage_q(stage_q),
  .ser_o  (ser_o)
);

// File: tb/piso_shift_reg_test.sv
`timescale 1ns/1ps
module piso_shift_reg_test;
  logic       clk = 1'b0;
  logic       rst_n, en_n, ld_n, ser_in;
  logic [7:0] par_a, par_b;
  logic       link, tail_out;
  bit         mod_a[$];
  bit         mod_b[$];
  int         vectors = 0;
  int         errors = 0;

  always #10 clk = ~clk;

  piso_shift_reg #(.WIDTH(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_ni(en_n), .load_ni(ld_n),
    .ser_i(ser_in), .par_i(par_a), .ser_o(link)
  );

  piso_shift_reg #(.WIDTH(8)) u_tail (
    .clk_i(clk), .rst_ni(rst_n), .en_ni(en_n), .load_ni(ld_n),
    .ser_i(link), .par_i(par_b), .ser_o(tail_out)
  );

  task automatic check_val(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    mod_a = {};
    mod_b = {};
    for (int i = 0; i < 8; i++) begin
      mod_a.push_back(1'b0);
      mod_b.push_back(1'b0);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic cycle(logic en, logic ld, logic s, string tag);
    bit a_top;
    en_n = en; ld_n = ld; ser_in = s;
    @(posedge clk);
    a_top = mod_a[0];
    if (!en) begin
      if (!ld) begin
        mod_a = {};
        mod_b = {};
        for (int i = 7; i >= 0; i--) begin
          mod_a.push_back(par_a[i]);
          mod_b.push_back(par_b[i]);
        end
      end else begin
        void'(mod_a.pop_front()); mod_a.push_back(s);
        void'(mod_b.pop_front()); mod_b.push_back(a_top);
      end
    end
    @(negedge clk);
    check_val(tag, {15'd0, link}, {15'd0, mod_a[0]});
    check_val(tag, {15'd0, tail_out}, {15'd0, mod_b[0]});
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [7:0]  seq_a;
    logic [15:0] seq_t;
    logic [23:0] pat;
    rst_n = 1'b0; en_n = 1'b1; ld_n = 1'b1; ser_in = 1'b0;
    par_a = 8'h00; par_b = 8'h00;
    model_clear();
    @(negedge clk); @(negedge clk);
    check_val("R1 clear at start", {14'd0, link, tail_out}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_val("R8 idle after release", {14'd0, link, tail_out}, 16'd0);
    cycle(1'b0, 1'b1, 1'b0, "R8 zero shift");

    // R3 parallel load into both instances
    par_a = 8'hB4; par_b = 8'h3C;
    cycle(1'b0, 1'b0, 1'b0, "R3");
    check_val("R3 top bits", {14'd0, link, tail_out}, {14'd0, 1'b1, 1'b0});

    // R2 disabled: load and serial changes must not land
    par_a = 8'h4B; par_b = 8'hC3;
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, 1'b1, "R2");
    cycle(1'b1, 1'b1, 1'b1, "R2 shift blocked");
    par_a = 8'hB4; par_b = 8'h3C;

    // R5 / R7 unload both words through the chain
    for (int i = 0; i < 16; i++) begin
      if (i < 8) seq_a[7-i] = link;
      seq_t[15-i] = tail_out;
      cycle(1'b0, 1'b1, 1'b0, "R4");
    end
    check_val("R5 word order", {8'd0, seq_a}, {8'd0, 8'hB4});
    check_val("R7 chained order", seq_t, {8'h3C, 8'hB4});

    // R6 serial delay through one instance
    pat = 24'h5A_C3E1;
    for (int i = 0; i < 24; i++) begin
      cycle(1'b0, 1'b1, pat[i], "R4 stream");
      if (i >= 7) check_val("R6 delay", {15'd0, link}, {15'd0, pat[i-7]});
    end

    // R1 clear in the middle of shifting, between edges
    par_a = 8'hFF; par_b = 8'hFF;
    cycle(1'b0, 1'b0, 1'b1, "R3 ones");
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, 1'b1, "R4 ones");
    #3 rst_n = 1'b0;
    #1 check_val("R1 immediate", {14'd0, link, tail_out}, 16'd0);
    model_clear();
    en_n = 1'b0; ld_n = 1'b0;
    @(negedge clk);
    check_val("R1 overrides load", {14'd0, link, tail_out}, 16'd0);
    rst_n = 1'b1;

    // R2 load blocked by enable after clear
    par_a = 8'h81; par_b = 8'h81;
    cycle(1'b1, 1'b0, 1'b0, "R2 load blocked");
    check_val("R2 still empty", {14'd0, link, tail_out}, 16'd0);
    cycle(1'b0, 1'b0, 1'b0, "R3 after clear");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule